// File: doc/BRIEF.md
# PLL Power-Save Clock Sequencer

This block moves a chip between its fast PLL-derived system clock and a slow oscillator bypass clock. It also drives the PLL sleep and PLL reset controls in the only order that is safe. Software raises a one-cycle request to enter power-save or to leave it. When entering, the sequencer first selects the oscillator and only then puts the PLL to sleep. When leaving, it wakes the PLL, holds PLL reset for a fixed number of slow cycles, waits out a fixed lock time, and only then selects the PLL again. A busy flag shows that a sequence is running. Requests that arrive while the block is busy, or that do not fit the current state, are dropped.

The block also holds three power-save bits. One turns off the converter. One turns off the converter's wake-up unit, and it only takes effect while the converter bit is also set. One turns off the video-side units (slicer, acquisition, DAC, display generator). The video enables are also forced low whenever the bypass clock is selected. Every wait is a parameter counted in cycles of the block clock, which is the slow machine clock. The glitch-free clock multiplexer and the analog PLL sit outside the block.

Top module: `pll_psave_seq`

## Requirements
- R1: After reset, clk_sel=0, pll_rst=0, pll_sleep=0 and busy=0. ps_state reads 3'b111, so all three power-save bits are set and every video enable is 0.
- R2: In the stable run state, an enter_req pulse sampled at a clock edge sets clk_sel=1 after that edge. pll_sleep rises one edge later and then stays high.
- R3: pll_sleep is never 1 while clk_sel is 0.
- R4: In the sleep state, an exit_req pulse sampled at an edge drops pll_sleep after that edge. pll_rst rises one edge later and stays high for exactly RST_CYC cycles (default 3).
- R5: After pll_rst falls, clk_sel stays 1 for exactly LOCK_CYC cycles (default 38). It then returns to 0, and the block is back in the run state one cycle later.
- R6: busy is 0 only in the run state and the sleep state. It is 1 in every transition cycle.
- R7: enter_req has no effect outside the run state, and exit_req has no effect outside the sleep state. Outputs follow as if the request had not arrived.
- R8: Each bit of video_en is 1 only when clk_sel=0 and the video power-save bit (ps_state bit 2) is 0. Otherwise every bit is 0.
- R9: conv_en equals the inverse of ps_state bit 0. wake_en is 0 only when both ps_state bit 0 and ps_state bit 1 are set.
- R10: When ps_wr=1 at an edge, ps_state takes ps_wdata after that edge: bit 0 is the converter, bit 1 the wake-up unit, bit 2 the video units. Writes are accepted in any sequencer state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow machine clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enter_req | input | 1 | One-cycle request to enter power-save |
| exit_req | input | 1 | One-cycle request to leave power-save |
| ps_wr | input | 1 | Write strobe for the power-save bits |
| ps_wdata | input | 3 | New power-save bits {video, wake-up, converter} |
| clk_sel | output | 1 | 0 selects the PLL clock, 1 selects the oscillator bypass |
| pll_rst | output | 1 | PLL reset control |
| pll_sleep | output | 1 | PLL sleep control |
| busy | output | 1 | A sequence is in progress |
| video_en | output | NUM_VIDEO | Enables for the clock-hungry video units |
| conv_en | output | 1 | Converter enable |
| wake_en | output | 1 | Converter wake-up unit enable |
| ps_state | output | 3 | Current power-save bits |

## Verification
The assertions assume that enter_req, exit_req, ps_wr and ps_wdata are synchronous to clk and change only away from its rising edge. They also assume that rst_n is held low for at least one edge before the first request. The bench changes every input just after a falling edge, holds reset for several cycles, and only then issues directed and pseudo-random request pulses. Some of those pulses are deliberately sent in states where they must be dropped. The sequence timing is checked against a behavioural model that counts the remaining wait cycles on its own.

// File: rtl/psq_pkg.sv
package psq_pkg;

   typedef enum logic [2:0] {
      ST_RUN,
      ST_TO_OSC,
      ST_SLEEP,
      ST_WAKE,
      ST_RST,
      ST_LOCK,
      ST_TO_PLL
   } psq_state_e;

   typedef struct packed {
      logic video;
      logic wake;
      logic conv;
   } psq_ps_t;

   localparam psq_ps_t PS_RESET = '{video: 1'b1, wake: 1'b1, conv: 1'b1};

endpackage

// File: rtl/psq_timer.sv
module psq_timer #(
   parameter int CW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic [CW-1:0] limit,
   output logic          done
);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)             cnt_q <= '0;
      else if (clr)           cnt_q <= '0;
      else if (cnt_q != '1)   cnt_q <= cnt_q + 1'b1;
   end

   assign done = (cnt_q == limit);

endmodule

// File: rtl/psq_fsm.sv
module psq_fsm
   import psq_pkg::*;
#(
   parameter int RST_CYC  = 3,
   parameter int LOCK_CYC = 38
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enter_req,
   input  logic exit_req,
   output logic clk_sel,
   output logic pll_rst,
   output logic pll_sleep,
   output logic busy
);

   localparam int MAXC = (RST_CYC > LOCK_CYC) ? RST_CYC : LOCK_CYC;
   localparam int CW   = $clog2(MAXC + 1);

   generate
      if (RST_CYC < 1) begin : g_bad_rst
         $error("RST_CYC must be at least 1");
      end
      if (LOCK_CYC < 1) begin : g_bad_lock
         $error("LOCK_CYC must be at least 1");
      end
   endgenerate

   psq_state_e    state_q, state_d;
   logic          tmr_done;
   logic          tmr_clr;
   logic [CW-1:0] tmr_limit;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_RUN:    if (enter_req) state_d = ST_TO_OSC;
         ST_TO_OSC: state_d = ST_SLEEP;
         ST_SLEEP:  if (exit_req)  state_d = ST_WAKE;
         ST_WAKE:   state_d = ST_RST;
         ST_RST:    if (tmr_done)  state_d = ST_LOCK;
         ST_LOCK:   if (tmr_done)  state_d = ST_TO_PLL;
         ST_TO_PLL: state_d = ST_RUN;
         default:   state_d = ST_RUN;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= ST_RUN;
      else        state_q <= state_d;
   end

   assign tmr_clr   = (state_d != state_q);
   assign tmr_limit = (state_q == ST_RST) ? CW'(RST_CYC - 1) : CW'(LOCK_CYC - 1);

   psq_timer #(.CW(CW)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (tmr_clr),
      .limit (tmr_limit),
      .done  (tmr_done)
   );

   // outputs are a pure decode of the state register
   always_comb begin
      clk_sel   = !(state_q == ST_RUN || state_q == ST_TO_PLL);
      pll_sleep = (state_q == ST_SLEEP);
      pll_rst   = (state_q == ST_RST);
      busy      = !(state_q == ST_RUN || state_q == ST_SLEEP);
   end

   // R3
   sleep_needs_osc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pll_sleep |-> clk_sel);

   // R2
   osc_before_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pll_sleep) |-> $past(clk_sel));

   // R4
   rst_while_awake_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pll_rst |-> (!pll_sleep && clk_sel));

   // R5
   lock_before_pll_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(clk_sel) |-> $past(state_q == ST_LOCK));

   // R6
   idle_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pll_sleep || !clk_sel) && !busy |-> !pll_rst);

endmodule

// File: rtl/psq_ps_reg.sv
module psq_ps_reg
   import psq_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    wr,
   input  psq_ps_t wdata,
   output psq_ps_t bits,
   output logic    conv_en,
   output logic    wake_en
);

   always_ff @(posedge clk) begin
      if (!rst_n)  bits <= PS_RESET;
      else if (wr) bits <= wdata;
   end

   assign conv_en = !bits.conv;
   // the wake-up bit only bites while the converter itself is off
   assign wake_en = !(bits.conv && bits.wake);

   // R9
   wake_follows_conv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      conv_en |-> wake_en);

   // R10
   write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(wr) |-> bits == $past(wdata));

endmodule

// File: rtl/pll_psave_seq.sv
module pll_psave_seq
   import psq_pkg::*;
#(
   parameter int RST_CYC   = 3,
   parameter int LOCK_CYC  = 38,
   parameter int NUM_VIDEO = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 enter_req,
   input  logic                 exit_req,
   input  logic                 ps_wr,
   input  logic [2:0]           ps_wdata,
   output logic                 clk_sel,
   output logic                 pll_rst,
   output logic                 pll_sleep,
   output logic                 busy,
   output logic [NUM_VIDEO-1:0] video_en,
   output logic                 conv_en,
   output logic                 wake_en,
   output logic [2:0]           ps_state
);

   generate
      if (NUM_VIDEO < 1) begin : g_bad_video
         $error("NUM_VIDEO must be at least 1");
      end
   endgenerate

   psq_ps_t ps_bits;
   logic    video_ok;

   psq_fsm #(.RST_CYC(RST_CYC), .LOCK_CYC(LOCK_CYC)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .enter_req (enter_req),
      .exit_req  (exit_req),
      .clk_sel   (clk_sel),
      .pll_rst   (pll_rst),
      .pll_sleep (pll_sleep),
      .busy      (busy)
   );

   psq_ps_reg u_ps (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (ps_wr),
      .wdata   (psq_ps_t'(ps_wdata)),
      .bits    (ps_bits),
      .conv_en (conv_en),
      .wake_en (wake_en)
   );

   assign ps_state = ps_bits;
   assign video_ok = !clk_sel && !ps_bits.video;

   generate
      for (genvar i = 0; i < NUM_VIDEO; i++) begin : g_video
         assign video_en[i] = video_ok;
      end
   endgenerate

   // R8
   video_off_on_osc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clk_sel |-> (video_en == '0));

endmodule

// File: tb/pll_psave_seq_test.sv
module pll_psave_seq_test;

   localparam int RST_CYC   = 3;
   localparam int LOCK_CYC  = 38;
   localparam int NUM_VIDEO = 4;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 enter_req = 1'b0;
   logic                 exit_req = 1'b0;
   logic                 ps_wr = 1'b0;
   logic [2:0]           ps_wdata = 3'b000;
   logic                 clk_sel, pll_rst, pll_sleep, busy, conv_en, wake_en;
   logic [NUM_VIDEO-1:0] video_en;
   logic [2:0]           ps_state;

   int errors = 0;
   int checks = 0;
   bit finished = 1'b0;

   pll_psave_seq #(.RST_CYC(RST_CYC), .LOCK_CYC(LOCK_CYC), .NUM_VIDEO(NUM_VIDEO)) uut (
      .clk(clk), .rst_n(rst_n), .enter_req(enter_req), .exit_req(exit_req),
      .ps_wr(ps_wr), .ps_wdata(ps_wdata), .clk_sel(clk_sel), .pll_rst(pll_rst),
      .pll_sleep(pll_sleep), .busy(busy), .video_en(video_en), .conv_en(conv_en),
      .wake_en(wake_en), .ps_state(ps_state)
   );

   always #4 clk = ~clk;

   // behavioural model: phase 0 run, 1 to osc, 2 sleep, 3 wake, 4 reset, 5 lock, 6 to pll
   int       m_phase = 0;
   int       m_left  = 0;
   bit [2:0] m_ps    = 3'b111;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_phase = 0;
         m_ps    = 3'b111;
      end else begin
         if (ps_wr) m_ps = ps_wdata;
         case (m_phase)
            0: if (enter_req) m_phase = 1;
            1: m_phase = 2;
            2: if (exit_req) m_phase = 3;
            3: begin m_phase = 4; m_left = RST_CYC; end
            4: begin
               m_left = m_left - 1;
               if (m_left == 0) begin m_phase = 5; m_left = LOCK_CYC; end
            end
            5: begin
               m_left = m_left - 1;
               if (m_left == 0) m_phase = 6;
            end
            default: m_phase = 0;
         endcase
      end
   end

   task automatic chk(input bit ok, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d (t=%0t)", what, act, exp, $time);
      end
   endtask

   task automatic compare_all(input string ctx);
      bit                 e_sel, e_sleep, e_rst, e_busy;
      logic [NUM_VIDEO-1:0] e_vid;
      e_sel   = (m_phase >= 1 && m_phase <= 5);
      e_sleep = (m_phase == 2);
      e_rst   = (m_phase == 4);
      e_busy  = !(m_phase == 0 || m_phase == 2);
      e_vid   = (!e_sel && !m_ps[2]) ? '1 : '0;
      chk(clk_sel == e_sel,     {ctx, " R2 R5 clk_sel"}, clk_sel, e_sel);
      chk(pll_sleep == e_sleep, {ctx, " R3 pll_sleep"}, pll_sleep, e_sleep);
      chk(pll_rst == e_rst,     {ctx, " R4 pll_rst"}, pll_rst, e_rst);
      chk(busy == e_busy,       {ctx, " R6 busy"}, busy, e_busy);
      chk(video_en == e_vid,    {ctx, " R8 video_en"}, video_en, e_vid);
      chk(conv_en == !m_ps[0],  {ctx, " R9 conv_en"}, conv_en, !m_ps[0]);
      chk(wake_en == !(m_ps[0] && m_ps[1]), {ctx, " R9 wake_en"}, wake_en, !(m_ps[0] && m_ps[1]));
      chk(ps_state == m_ps,     {ctx, " R10 ps_state"}, ps_state, m_ps);
   endtask

   // one cycle: compare at the falling edge, then drive the next inputs
   task automatic cyc(input bit e, input bit x, input bit w, input logic [2:0] d, input string ctx);
      @(negedge clk);
      compare_all(ctx);
      enter_req = e;
      exit_req  = x;
      ps_wr     = w;
      ps_wdata  = d;
   endtask

   task automatic idle(input int n, input string ctx);
      for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 1'b0, 3'b000, ctx);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(clk_sel == 1'b0 && pll_rst == 1'b0 && pll_sleep == 1'b0 && busy == 1'b0,
          "R1 control outputs", {clk_sel, pll_rst, pll_sleep, busy}, 0);
      chk(ps_state == 3'b111, "R1 ps_state", ps_state, 7);
      chk(video_en == '0, "R1 video_en", video_en, 0);
      rst_n = 1'b1;
      idle(2, "R1");
      // R10: clear all power-save bits, video on
      cyc(1'b0, 1'b0, 1'b1, 3'b000, "R10");
      idle(3, "R10");
      // R2 entry, then R7 late requests while moving to the oscillator
      cyc(1'b1, 1'b0, 1'b0, 3'b000, "R2");
      cyc(1'b0, 1'b1, 1'b0, 3'b000, "R7");
      cyc(1'b1, 1'b0, 1'b0, 3'b000, "R7");
      idle(4, "R2");
      // R4 / R5 exit with spurious requests while busy
      cyc(1'b0, 1'b1, 1'b0, 3'b000, "R4");
      for (int i = 0; i < 50; i++) cyc(i[0], ~i[0], 1'b0, 3'b000, "R7");
      idle(4, "R5");
      // R9 all bit combinations, written mid-sequence
      for (int v = 0; v < 8; v++) begin
         cyc(v == 2, v == 5, 1'b1, v[2:0], "R9");
         idle(2, "R9");
      end
      // pseudo-random traffic
      for (int i = 0; i < 3000; i++) begin
         int r;
         r = $urandom_range(0, 99);
         cyc(r < 6, r >= 6 && r < 12, r >= 90, 3'($urandom_range(0, 7)), "RND");
      end
      idle(60, "R5");
      finished = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog R6 actual=1 expected=0");
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule